// File: doc/BRIEF.md
# I2C SDA Shift Datapath

This block is the data half of a two-wire serial transfer. It runs beside a separate clock generator, which hands it one-cycle strobes marking each falling and each rising edge of the serial clock. On the falling strobes it drives the next transmit bit onto SDA. A frame sends the data byte most significant bit first and then an acknowledge bit. On the rising strobes it samples the SDA pin. After nine samples it publishes a 9-bit receive word and raises a one-cycle valid flag.

The driven SDA level can be held back by a selectable number of system-clock cycles, so that data changes well clear of the clock edge. Separately, the pin driver can be switched off so that the line floats. While the interface is disabled, the SDA level comes from an idle-level input and both bit counters are held at zero. The receive word has two packings. A clock-phase control forces the normal packing whatever the packing select says.

Top module: `i2c_sda_datapath`

## Requirements
- R1: While reset is asserted and just after it, sda_out is 1, rx_word is 0 and rx_valid is 0.
- R2: While en is 0, the internal SDA level follows idle_level, and sda_out shows that level after the selected delay.
- R3: With en at 1, the first fall strobe of a frame captures tx_byte and tx_ack. The first nine fall strobes then drive tx_byte[7] down to tx_byte[0], followed by tx_ack. The tenth fall strobe starts the next frame.
- R4: With dly_sel = 0, sda_out takes the new bit on the same clock edge that registers the fall strobe.
- R5: With dly_sel = k (1 to 7), sda_out takes the new bit k+1 clock cycles after that edge, which gives 2 to 8 cycles of delay.
- R6: While sda_hiz is 1, sda_oe is 0 whatever the data is. The data path keeps running.
- R7: Every rise strobe samples sda_in. On the clock edge that registers the ninth rise strobe, rx_word is loaded and rx_valid is 1 for exactly that one cycle.
- R8: Normal packing: word bits 7..0 hold received bits 1..8, with bit 1 in word bit 7, and word bit 8 holds bit 9.
- R9: Alternate packing (alt_pack = 1, clk_phase = 0): word bits 6..0 hold received bits 1..7, with bit 1 in word bit 6. Word bit 8 holds bit 8 and word bit 7 holds bit 9.
- R10: When clk_phase is 1, normal packing applies even if alt_pack is 1.
- R11: Strobes that arrive while en is 0 are ignored. Dropping en in the middle of a frame restarts the bit count.
- R12: Between valid pulses, rx_word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (count-source) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Interface enable; 0 clears counters and loads idle level |
| idle_level | input | 1 | SDA level driven while disabled |
| scl_fall | input | 1 | One-cycle strobe at serial clock falling edge |
| scl_rise | input | 1 | One-cycle strobe at serial clock rising edge |
| tx_byte | input | 8 | Byte to transmit, MSB first |
| tx_ack | input | 1 | Ninth transmitted bit (ACK/NACK) |
| dly_sel | input | 3 | SDA output delay select: 0 none, k gives k+1 cycles |
| sda_hiz | input | 1 | Forces SDA driver off |
| alt_pack | input | 1 | Selects alternate receive packing |
| clk_phase | input | 1 | When 1, forces normal packing |
| sda_in | input | 1 | SDA pin input |
| sda_out | output | 1 | SDA data level to the pad |
| sda_oe | output | 1 | SDA driver enable (0 = high impedance) |
| rx_word | output | 9 | Received 9-bit word |
| rx_valid | output | 1 | One-cycle pulse when rx_word is loaded |

## Verification
The bench goes after the bit order across back-to-back frames. A design that failed to reload at the frame boundary would send the acknowledge bit twice, or shift stale data into the next byte. It times the longest delay to the exact cycle, where an off-by-one tap would put the edge one cycle early or late. It also checks each packing, including alternate packing overridden by clock phase; a wrong mapping shows up as a swapped bit 7 or bit 8. Finally, it drops the enable mid-frame and sends strobes while disabled: a design that kept counting would then raise valid early or not at all.

// File: rtl/i2c_sda_pkg.sv
package i2c_sda_pkg;

  typedef enum logic {
    PACK_NORMAL = 1'b0,
    PACK_ALT    = 1'b1
  } pack_mode_e;

  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_SEL_W  = 3;

endpackage

// File: rtl/i2c_sda_tx_shift.sv
module i2c_sda_tx_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              idle_level,
  input  logic              fall_stb,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              tx_ack,
  output logic              tx_bit
);

  localparam int unsigned FRAME_W = DATA_W + 1;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  logic [DATA_W-1:0] sh_q, sh_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              bit_q, bit_n;

  always_comb begin
    sh_n  = sh_q;
    cnt_n = cnt_q;
    bit_n = bit_q;
    if (!en) begin
      bit_n = idle_level;
      cnt_n = '0;
    end else if (fall_stb) begin
      if (cnt_q == '0) begin
        bit_n = tx_byte[DATA_W-1];
        sh_n  = {tx_byte[DATA_W-2:0], tx_ack};
        cnt_n = CNT_W'(1);
      end else begin
        bit_n = sh_q[DATA_W-1];
        sh_n  = {sh_q[DATA_W-2:0], 1'b1};
        cnt_n = (cnt_q == CNT_W'(FRAME_W - 1)) ? '0 : cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '1;
      cnt_q <= '0;
      bit_q <= 1'b1;
    end else begin
      sh_q  <= sh_n;
      cnt_q <= cnt_n;
      bit_q <= bit_n;
    end
  end

  assign tx_bit = bit_q;

endmodule

// File: rtl/i2c_sda_delay.sv
module i2c_sda_delay #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [SEL_W-1:0] sel,
  output logic             dout
);

  localparam int unsigned TAPS = 1 << SEL_W;

  logic [TAPS-1:0] line_q;
  logic [TAPS-1:0] line_n;

  genvar g;
  generate
    for (g = 0; g < TAPS; g++) begin : g_stage
      if (g == 0) begin : g_head
        always_comb line_n[g] = din;
      end else begin : g_body
        always_comb line_n[g] = line_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '1;
    else        line_q <= line_n;
  end

  // code 0: straight through; code k: tap k, which is k+1 registers deep
  always_comb begin
    if (sel == '0) dout = din;
    else           dout = line_q[sel];
  end

endmodule

// File: rtl/i2c_sda_rx_shift.sv
module i2c_sda_rx_shift
  import i2c_sda_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            rise_stb,
  input  logic            sda_in,
  input  pack_mode_e      mode,
  output logic [DATA_W:0] rx_word,
  output logic            rx_valid
);

  localparam int unsigned FRAME_W = DATA_W + 1;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  logic [DATA_W-1:0]  sh_q, sh_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [DATA_W:0]    word_q, word_n;
  logic               vld_q, vld_n;
  logic [FRAME_W-1:0] full;

  // full[FRAME_W-1] is the first bit of the frame, full[0] the last
  assign full = {sh_q, sda_in};

  always_comb begin
    sh_n   = sh_q;
    cnt_n  = cnt_q;
    word_n = word_q;
    vld_n  = 1'b0;
    if (!en) begin
      cnt_n = '0;
    end else if (rise_stb) begin
      if (cnt_q == CNT_W'(FRAME_W - 1)) begin
        cnt_n = '0;
        vld_n = 1'b1;
        if (mode == PACK_ALT) word_n = {full[1], full[0], full[FRAME_W-1:2]};
        else                  word_n = {full[0], full[FRAME_W-1:1]};
      end else begin
        cnt_n = cnt_q + CNT_W'(1);
        sh_n  = {sh_q[DATA_W-2:0], sda_in};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      sh_q   <= sh_n;
      cnt_q  <= cnt_n;
      word_q <= word_n;
      vld_q  <= vld_n;
    end
  end

  assign rx_word  = word_q;
  assign rx_valid = vld_q;

endmodule

// File: rtl/i2c_sda_datapath.sv
module i2c_sda_datapath
  import i2c_sda_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned SEL_W  = DEF_SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              idle_level,
  input  logic              scl_fall,
  input  logic              scl_rise,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              tx_ack,
  input  logic [SEL_W-1:0]  dly_sel,
  input  logic              sda_hiz,
  input  logic              alt_pack,
  input  logic              clk_phase,
  input  logic              sda_in,
  output logic              sda_out,
  output logic              sda_oe,
  output logic [DATA_W:0]   rx_word,
  output logic              rx_valid
);

  logic       tx_bit;
  pack_mode_e mode;

  always_comb mode = (alt_pack && !clk_phase) ? PACK_ALT : PACK_NORMAL;

  i2c_sda_tx_shift #(.DATA_W(DATA_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .idle_level (idle_level),
    .fall_stb   (scl_fall),
    .tx_byte    (tx_byte),
    .tx_ack     (tx_ack),
    .tx_bit     (tx_bit)
  );

  i2c_sda_delay #(.SEL_W(SEL_W)) u_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (tx_bit),
    .sel   (dly_sel),
    .dout  (sda_out)
  );

  i2c_sda_rx_shift #(.DATA_W(DATA_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .rise_stb (scl_rise),
    .sda_in   (sda_in),
    .mode     (mode),
    .rx_word  (rx_word),
    .rx_valid (rx_valid)
  );

  assign sda_oe = ~sda_hiz;

endmodule

// File: rtl/i2c_sda_datapath_chk.sv
module i2c_sda_datapath_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SEL_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             idle_level,
  input logic             sda_hiz,
  input logic [SEL_W-1:0] dly_sel,
  input logic             tx_bit,
  input logic             sda_out,
  input logic             sda_oe,
  input logic [DATA_W:0]  rx_word,
  input logic             rx_valid
);

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> tx_bit == $past(idle_level)); // R2

  AST_NO_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    dly_sel == '0 |-> sda_out == tx_bit); // R4

  AST_DELAY_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    dly_sel == SEL_W'(1) |-> sda_out == $past(tx_bit, 2)); // R5

  AST_HIZ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    sda_hiz |-> !sda_oe); // R6

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R7

  AST_NO_VALID_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !rx_valid); // R11

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_word)); // R12

endmodule

bind i2c_sda_datapath i2c_sda_datapath_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .idle_level (idle_level),
  .sda_hiz    (sda_hiz),
  .dly_sel    (dly_sel),
  .tx_bit     (tx_bit),
  .sda_out    (sda_out),
  .sda_oe     (sda_oe),
  .rx_word    (rx_word),
  .rx_valid   (rx_valid)
);

// File: tb/i2c_sda_datapath_tb.sv
`timescale 1ns/1ps
module i2c_sda_datapath_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en, idle_level, scl_fall, scl_rise, tx_ack, sda_hiz;
  logic       alt_pack, clk_phase, sda_in;
  logic [7:0] tx_byte;
  logic [2:0] dly_sel;
  logic       sda_out, sda_oe, rx_valid;
  logic [8:0] rx_word;

  int checks   = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  i2c_sda_datapath dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .idle_level(idle_level),
    .scl_fall(scl_fall), .scl_rise(scl_rise), .tx_byte(tx_byte),
    .tx_ack(tx_ack), .dly_sel(dly_sel), .sda_hiz(sda_hiz),
    .alt_pack(alt_pack), .clk_phase(clk_phase), .sda_in(sda_in),
    .sda_out(sda_out), .sda_oe(sda_oe), .rx_word(rx_word), .rx_valid(rx_valid)
  );

  // fields: tx_byte, tx_ack, rx pattern (bit 8 sent first), alt, phase, delay
  localparam int NVEC = 6;
  localparam logic [22:0] VEC [NVEC] = '{
    {8'hA5, 1'b0, 9'h155, 1'b0, 1'b0, 3'd0},
    {8'h3C, 1'b1, 9'h0CA, 1'b1, 1'b0, 3'd1},
    {8'hFF, 1'b1, 9'h1FE, 1'b1, 1'b1, 3'd2},
    {8'h00, 1'b0, 9'h001, 1'b0, 1'b0, 3'd4},
    {8'h81, 1'b1, 9'h102, 1'b1, 1'b0, 3'd7},
    {8'h5A, 1'b0, 9'h0B7, 1'b0, 1'b1, 3'd3}
  };

  function automatic logic [8:0] exp_word(logic [8:0] pat, logic alt, logic ph);
    if (alt && !ph) return {pat[1], pat[0], pat[8:2]};
    return {pat[0], pat[8:1]};
  endfunction

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_fall();
    scl_fall = 1'b1;
    @(negedge clk);
    scl_fall = 1'b0;
  endtask

  task automatic pulse_rise(logic b);
    sda_in   = b;
    scl_rise = 1'b1;
    @(negedge clk);
    scl_rise = 1'b0;
  endtask

  task automatic run_frame(logic [7:0] byt, logic ack, logic [8:0] pat, int dly);
    tx_byte = byt;
    tx_ack  = ack;
    for (int i = 0; i < 9; i++) begin
      pulse_fall();
      if (dly != 0) repeat (dly + 1) @(negedge clk);
      check((i < 8) ? "R3" : "R3 ack", {8'd0, sda_out}, {8'd0, (i < 8) ? byt[7-i] : ack});
      if (i == 8) check("R7 no early valid", {8'd0, rx_valid}, 9'd0);
      pulse_rise(pat[8-i]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [8:0] held;
    logic       seen;
    rst_n = 1'b0; en = 1'b0; idle_level = 1'b1; scl_fall = 1'b0; scl_rise = 1'b0;
    tx_byte = 8'h00; tx_ack = 1'b0; dly_sel = 3'd0; sda_hiz = 1'b0;
    alt_pack = 1'b0; clk_phase = 1'b0; sda_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 sda_out", {8'd0, sda_out}, 9'd1);
    check("R1 rx_word", rx_word, 9'd0);
    check("R1 rx_valid", {8'd0, rx_valid}, 9'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {8'd0, rx_valid}, 9'd0);

    // R2: idle level while disabled
    idle_level = 1'b0;
    @(negedge clk);
    check("R2 idle low", {8'd0, sda_out}, 9'd0);
    idle_level = 1'b1;
    @(negedge clk);
    check("R2 idle high", {8'd0, sda_out}, 9'd1);

    // R11: strobes while disabled are ignored
    seen = 1'b0;
    for (int i = 0; i < 10; i++) begin
      pulse_rise(1'b1);
      if (rx_valid) seen = 1'b1;
    end
    @(negedge clk);
    check("R11 no valid when disabled", {8'd0, seen}, 9'd0);
    check("R11 word untouched", rx_word, 9'd0);

    // table walk: frames back to back with en held
    en = 1'b1;
    for (int v = 0; v < NVEC; v++) begin
      alt_pack  = VEC[v][4];
      clk_phase = VEC[v][3];
      dly_sel   = VEC[v][2:0];
      run_frame(VEC[v][22:15], VEC[v][14], VEC[v][13:5], int'(VEC[v][2:0]));
      held = exp_word(VEC[v][13:5], VEC[v][4], VEC[v][3]);
      check("R7 valid", {8'd0, rx_valid}, 9'd1);
      check((VEC[v][4] && !VEC[v][3]) ? "R9 alt word" : (VEC[v][4] ? "R10 forced normal" : "R8 normal word"),
            rx_word, held);
      @(negedge clk);
      check("R7 single pulse", {8'd0, rx_valid}, 9'd0);
      repeat (3) @(negedge clk);
      check("R12 hold", rx_word, held);
    end

    // R11: dropping en mid-frame restarts the count
    dly_sel = 3'd0; alt_pack = 1'b0; clk_phase = 1'b0;
    for (int i = 0; i < 4; i++) pulse_rise(1'b1);
    en = 1'b0;
    @(negedge clk);
    en = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 8; i++) begin
      pulse_rise(i[0]);
      if (rx_valid) seen = 1'b1;
    end
    check("R11 restart no early valid", {8'd0, seen}, 9'd0);
    pulse_rise(1'b1);
    check("R11 restart valid", {8'd0, rx_valid}, 9'd1);
    check("R11 restart word", rx_word, exp_word(9'b010101011, 1'b0, 1'b0));

    // R5: longest delay, edge placed exactly
    en = 1'b0; idle_level = 1'b0; dly_sel = 3'd7;
    repeat (10) @(negedge clk);
    en = 1'b1; tx_byte = 8'h80; tx_ack = 1'b0;
    pulse_fall();
    repeat (7) @(negedge clk);
    check("R5 before edge", {8'd0, sda_out}, 9'd0);
    @(negedge clk);
    check("R5 at 8 cycles", {8'd0, sda_out}, 9'd1);

    // R4: zero delay edge follows fall strobe directly
    dly_sel = 3'd0;
    @(negedge clk);
    pulse_fall();
    check("R4 zero delay", {8'd0, sda_out}, 9'd0);

    // R6: driver off, data still moving
    en = 1'b0; sda_hiz = 1'b1; idle_level = 1'b1;
    @(negedge clk);
    check("R6 oe off", {8'd0, sda_oe}, 9'd0);
    check("R6 data live", {8'd0, sda_out}, 9'd1);
    idle_level = 1'b0;
    @(negedge clk);
    check("R6 data follows", {8'd0, sda_out}, 9'd0);
    sda_hiz = 1'b0;
    @(negedge clk);
    check("R6 oe back", {8'd0, sda_oe}, 9'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule